// File: doc/BRIEF.md
# Serial Memory Status Register Responder

This block is the slave-side logic behind the status register of a small serial memory. A single-wire transaction layer, which is outside the block, decodes the line and hands over whole bytes. It also reports the master's acknowledge (MAK) or no-acknowledge (NoMAK) that follows every byte. The block decodes four commands: set-latch, clear-latch, write-status and read-status. It holds the write-enable latch and the two block-protect bits, and it reports write-in-progress. Write-in-progress combines a busy input from the array write timer with the block's own timer for status writes.

A command starts with one command byte. Set-latch and clear-latch take effect on the NoMAK that follows that byte. Write-status takes one data byte and takes effect on the NoMAK after it. Read-status offers one status byte. Each MAK after that byte makes the block offer it again, built from the flags as they stand at that moment. A NoMAK ends the command. Read-status is accepted at any time, including while a write is running. The block-protect bits hold their value across the functional reset. Only the separate power-up restore input loads them.

Top module: `stat_reg_responder`

## Requirements
- R1: The status byte carries write-in-progress in bit 0, the write-enable latch in bit 1, BP0 in bit 2 and BP1 in bit 3. Bits 7 to 4 are always 0. The read-status code is 0x05. The first status byte is offered after the MAK that follows the read-status code.
- R2: Code 0x06 followed by a NoMAK sets the write-enable latch. Code 0x04 followed by a NoMAK clears it. The `wel` output shows the result in the cycle after the NoMAK.
- R3: Write-status has code 0x01. The sequence is the code, a MAK, one data byte, then a NoMAK. It loads BP1 from data bit 3 and BP0 from data bit 2, but only if the latch is 1 and write-in-progress is 0. Otherwise nothing changes.
- R4: An accepted write-status holds write-in-progress at 1 for exactly WR_CYCLES cycles, starting in the cycle after the final NoMAK. The write-enable latch clears in the same cycle that write-in-progress returns to 0.
- R5: While `arr_busy` is 1, write-in-progress reads 1. A one-cycle `arr_done` pulse clears the write-enable latch.
- R6: A MAK after a status byte makes the block offer another status byte. A NoMAK ends the command, no further byte is offered, and the next byte received is decoded as a new command.
- R7: Each re-offered status byte shows write-in-progress and the latch as they stand when that byte is offered.
- R8: If read-status arrives while a status write is still running, every byte returned shows the new block-protect values.
- R9: `rst_n` clears the latch and the status write timer and returns the sequencer to idle. The block-protect bits keep their value through it. Only `nv_init_n` loads them, with BP_INIT.
- R10: A command byte with any other code is ignored, together with every byte that follows it, until the next NoMAK. No flag changes and no byte is offered.
- R11: After reset the latch is 0, write-in-progress equals `arr_busy`, and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low functional reset, leaves block-protect bits untouched |
| nv_init_n | input | 1 | Active-low power-up restore of the block-protect bits to BP_INIT |
| rx_vld | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ack_vld | input | 1 | Master acknowledge slot for the last byte is present this cycle |
| ack_mak | input | 1 | 1 for MAK, 0 for NoMAK, valid with ack_vld |
| tx_rdy | input | 1 | Transaction layer takes the offered byte this cycle |
| tx_vld | output | 1 | A status byte is offered |
| tx_byte | output | 8 | Offered status byte, live while tx_vld is 1 |
| arr_busy | input | 1 | Array write timer is running |
| arr_done | input | 1 | One-cycle pulse when an array write completes |
| wel | output | 1 | Write-enable latch, gates array writes |
| wip | output | 1 | Write-in-progress |
| bp | output | 2 | Block-protect bits, bit 1 is BP1 |

## Verification
The assertions take for granted that the transaction layer keeps to the byte handshake. A single-cycle byte or acknowledge slot never overlaps another one, an acknowledge slot comes only after a byte, and `tx_rdy` is raised only while a byte is offered. Both reset inputs are asserted together at power-up. The bench's tasks drive every byte, acknowledge and take as a one-cycle pulse at the falling edge, one at a time and always in command order. They never raise `tx_rdy` until `tx_vld` has been seen. `arr_busy` changes only between commands or between two status bytes of one read.

// File: rtl/stat_pkg.sv
package stat_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_SETL,
      OP_CLRL,
      OP_WRST,
      OP_RDST
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CACK,
      S_DATA,
      S_DACK,
      S_SEND,
      S_SACK,
      S_SKIP
   } seq_e;

   localparam int STAT_W  = 8;
   localparam int BP_W    = 2;
   localparam int BP_LSB  = 2;

   function automatic logic [STAT_W-1:0] pack_status(
      input logic            wip_i,
      input logic            wel_i,
      input logic [BP_W-1:0] bp_i);
      logic [STAT_W-1:0] r;
      r = '0;
      r[0] = wip_i;
      r[1] = wel_i;
      r[BP_LSB +: BP_W] = bp_i;
      return r;
   endfunction

endpackage

// File: rtl/stat_seq.sv
module stat_seq
   import stat_pkg::*;
#(
   parameter int           BYTE_W  = 8,
   parameter logic [7:0]   CODE_SETL = 8'h06,
   parameter logic [7:0]   CODE_CLRL = 8'h04,
   parameter logic [7:0]   CODE_WRST = 8'h01,
   parameter logic [7:0]   CODE_RDST = 8'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_vld,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              ack_vld,
   input  logic              ack_mak,
   input  logic              tx_rdy,
   output logic              tx_vld,
   output logic              set_wel,
   output logic              clr_wel,
   output logic              wrst_req,
   output logic [BP_W-1:0]   wrst_bp
);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("stat_seq: BYTE_W must be 8");
      end
      if (CODE_SETL == CODE_CLRL || CODE_SETL == CODE_WRST || CODE_SETL == CODE_RDST ||
          CODE_CLRL == CODE_WRST || CODE_CLRL == CODE_RDST || CODE_WRST == CODE_RDST)
      begin : g_bad_codes
         $error("stat_seq: command codes must be distinct");
      end
   endgenerate

   seq_e            st_q, st_d;
   op_e             op_q, op_d;
   logic [BP_W-1:0] dat_q, dat_d;
   op_e             op_dec;

   always_comb begin
      if      (rx_byte == CODE_SETL) op_dec = OP_SETL;
      else if (rx_byte == CODE_CLRL) op_dec = OP_CLRL;
      else if (rx_byte == CODE_WRST) op_dec = OP_WRST;
      else if (rx_byte == CODE_RDST) op_dec = OP_RDST;
      else                           op_dec = OP_NONE;
   end

   always_comb begin
      st_d     = st_q;
      op_d     = op_q;
      dat_d    = dat_q;
      set_wel  = 1'b0;
      clr_wel  = 1'b0;
      wrst_req = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (rx_vld) begin
               op_d = op_dec;
               st_d = S_CACK;
            end
         end
         S_CACK: begin
            if (ack_vld) begin
               if (ack_mak) begin
                  unique case (op_q)
                     OP_RDST: st_d = S_SEND;
                     OP_WRST: st_d = S_DATA;
                     default: st_d = S_SKIP;
                  endcase
               end else begin
                  set_wel = (op_q == OP_SETL);
                  clr_wel = (op_q == OP_CLRL);
                  st_d    = S_IDLE;
               end
            end
         end
         S_DATA: begin
            if (rx_vld) begin
               dat_d = rx_byte[BP_LSB +: BP_W];
               st_d  = S_DACK;
            end
         end
         S_DACK: begin
            if (ack_vld) begin
               if (ack_mak) begin
                  st_d = S_SKIP;
               end else begin
                  wrst_req = 1'b1;
                  st_d     = S_IDLE;
               end
            end
         end
         S_SEND: begin
            if (tx_rdy) st_d = S_SACK;
         end
         S_SACK: begin
            if (ack_vld) st_d = ack_mak ? S_SEND : S_IDLE;
         end
         S_SKIP: begin
            if (ack_vld && !ack_mak) st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         op_q  <= OP_NONE;
         dat_q <= '0;
      end else begin
         st_q  <= st_d;
         op_q  <= op_d;
         dat_q <= dat_d;
      end
   end

   assign tx_vld  = (st_q == S_SEND);
   assign wrst_bp = dat_q;

   // R6: an offered byte stays offered until taken
   a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld && !tx_rdy |=> tx_vld);

   // R6: a NoMAK after a status byte ends the offer
   a_r6_nomak_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_SACK) && ack_vld && !ack_mak |=> !tx_vld);

   // R2: set and clear requests never coincide
   a_r2_set_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_wel, clr_wel, wrst_req}));

endmodule

// File: rtl/stat_flags.sv
module stat_flags
   import stat_pkg::*;
#(
   parameter int              WR_CYCLES = 32,
   parameter logic [BP_W-1:0] BP_INIT   = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nv_init_n,
   input  logic            set_wel,
   input  logic            clr_wel,
   input  logic            wrst_req,
   input  logic [BP_W-1:0] wrst_bp,
   input  logic            arr_busy,
   input  logic            arr_done,
   output logic            wel,
   output logic            wip,
   output logic [BP_W-1:0] bp
);

   localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES + 1) : 1;

   generate
      if (WR_CYCLES < 0) begin : g_bad_cycles
         $error("stat_flags: WR_CYCLES must not be negative");
      end
   endgenerate

   logic            wel_q;
   logic [BP_W-1:0] bp_q;
   logic            busy_int;
   logic            wr_end;
   logic            accept;

   assign accept = wrst_req && wel_q && !wip;

   generate
      if (WR_CYCLES > 0) begin : g_timer
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (accept)       cnt_q <= CNT_W'(WR_CYCLES);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign busy_int = (cnt_q != '0);
         assign wr_end   = (cnt_q == CNT_W'(1));

         // R4: an accepted status write raises write-in-progress next cycle
         a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> wip);
      end else begin : g_instant
         assign busy_int = 1'b0;
         assign wr_end   = accept;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else begin
         if (clr_wel || arr_done || wr_end) wel_q <= 1'b0;
         else if (set_wel)                  wel_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge nv_init_n) begin
      if (!nv_init_n)  bp_q <= BP_INIT;
      else if (accept) bp_q <= wrst_bp;
   end

   assign wel = wel_q;
   assign wip = busy_int | arr_busy;
   assign bp  = bp_q;

   // R2: the latch rises only on a set request
   a_r2_wel_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(set_wel));

   // R4: the latch falls only on clear, array completion or status write end
   a_r4_wel_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel_q) |-> $past(clr_wel || arr_done || busy_int || wrst_req));

   // R3: block-protect bits change only on an accepted write while latched and idle
   a_r3_bp_guarded: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
      !$stable(bp_q) |-> $past(wrst_req && wel_q && !wip));

endmodule

// File: rtl/stat_fmt.sv
module stat_fmt
   import stat_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              wip,
   input  logic              wel,
   input  logic [BP_W-1:0]   bp,
   output logic [BYTE_W-1:0] stat_byte
);

   generate
      if (BYTE_W < STAT_W) begin : g_bad_width
         $error("stat_fmt: BYTE_W too small for status layout");
      end
   endgenerate

   assign stat_byte = BYTE_W'(pack_status(wip, wel, bp));

endmodule

// File: rtl/stat_reg_responder.sv
module stat_reg_responder
   import stat_pkg::*;
#(
   parameter int         WR_CYCLES = 32,
   parameter logic [1:0] BP_INIT   = 2'b00,
   parameter logic [7:0] CODE_SETL = 8'h06,
   parameter logic [7:0] CODE_CLRL = 8'h04,
   parameter logic [7:0] CODE_WRST = 8'h01,
   parameter logic [7:0] CODE_RDST = 8'h05
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nv_init_n,
   input  logic       rx_vld,
   input  logic [7:0] rx_byte,
   input  logic       ack_vld,
   input  logic       ack_mak,
   input  logic       tx_rdy,
   output logic       tx_vld,
   output logic [7:0] tx_byte,
   input  logic       arr_busy,
   input  logic       arr_done,
   output logic       wel,
   output logic       wip,
   output logic [1:0] bp
);

   logic            set_wel;
   logic            clr_wel;
   logic            wrst_req;
   logic [BP_W-1:0] wrst_bp;

   stat_seq #(
      .BYTE_W    (8),
      .CODE_SETL (CODE_SETL),
      .CODE_CLRL (CODE_CLRL),
      .CODE_WRST (CODE_WRST),
      .CODE_RDST (CODE_RDST)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_vld   (rx_vld),
      .rx_byte  (rx_byte),
      .ack_vld  (ack_vld),
      .ack_mak  (ack_mak),
      .tx_rdy   (tx_rdy),
      .tx_vld   (tx_vld),
      .set_wel  (set_wel),
      .clr_wel  (clr_wel),
      .wrst_req (wrst_req),
      .wrst_bp  (wrst_bp)
   );

   stat_flags #(
      .WR_CYCLES (WR_CYCLES),
      .BP_INIT   (BP_INIT)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .nv_init_n (nv_init_n),
      .set_wel   (set_wel),
      .clr_wel   (clr_wel),
      .wrst_req  (wrst_req),
      .wrst_bp   (wrst_bp),
      .arr_busy  (arr_busy),
      .arr_done  (arr_done),
      .wel       (wel),
      .wip       (wip),
      .bp        (bp)
   );

   stat_fmt #(
      .BYTE_W (8)
   ) u_fmt (
      .wip       (wip),
      .wel       (wel),
      .bp        (bp),
      .stat_byte (tx_byte)
   );

   // R1: offered bytes never carry anything in the upper nibble
   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |-> (tx_byte[7:4] == 4'b0000));

   // R5: array busy always shows as write-in-progress
   a_r5_busy_seen: assert property (@(posedge clk) disable iff (!rst_n)
      arr_busy |-> wip);

   // R7: offered byte tracks the live latch and busy flags
   a_r7_live_flags: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |-> (tx_byte[1] == wel) && (tx_byte[0] == wip));

endmodule

// File: tb/stat_reg_responder_bench.sv
`timescale 1ns/1ps
module stat_reg_responder_bench;

   localparam int W = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nv_init_n = 1'b0;
   logic       rx_vld = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       ack_vld = 1'b0;
   logic       ack_mak = 1'b0;
   logic       tx_rdy = 1'b0;
   logic       tx_vld;
   logic [7:0] tx_byte;
   logic       arr_busy = 1'b0;
   logic       arr_done = 1'b0;
   logic       wel;
   logic       wip;
   logic [1:0] bp;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   stat_reg_responder #(.WR_CYCLES(W), .BP_INIT(2'b00)) u_stat_reg_responder (
      .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n),
      .rx_vld(rx_vld), .rx_byte(rx_byte), .ack_vld(ack_vld), .ack_mak(ack_mak),
      .tx_rdy(tx_rdy), .tx_vld(tx_vld), .tx_byte(tx_byte),
      .arr_busy(arr_busy), .arr_done(arr_done),
      .wel(wel), .wip(wip), .bp(bp));

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b);
      rx_vld = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic put_ack(input logic mak);
      ack_vld = 1'b1; ack_mak = mak;
      @(negedge clk);
      ack_vld = 1'b0; ack_mak = 1'b0;
   endtask

   task automatic take_byte(input string req, output logic [7:0] b);
      int t;
      t = 0;
      while (!tx_vld && t < 20) begin
         @(negedge clk);
         t++;
      end
      if (!tx_vld) begin
         n_chk++; n_bad++;
         $display("FAIL %s no byte offered: actual 0 expected 1", req);
         b = 8'hxx;
      end else begin
         b = tx_byte;
         tx_rdy = 1'b1;
         @(negedge clk);
         tx_rdy = 1'b0;
      end
   endtask

   task automatic simple_cmd(input logic [7:0] code);
      put_byte(code);
      put_ack(1'b0);
   endtask

   task automatic write_status(input logic [7:0] d);
      put_byte(8'h01);
      put_ack(1'b1);
      put_byte(d);
      put_ack(1'b0);
   endtask

   task automatic read_once(input string req, output logic [7:0] b);
      put_byte(8'h05);
      put_ack(1'b1);
      take_byte(req, b);
      put_ack(1'b0);
   endtask

   task automatic t_reset_state();
      check("R11", "wel after reset", {7'b0, wel}, 8'h00);
      check("R11", "wip after reset", {7'b0, wip}, 8'h00);
      check("R11", "tx_vld after reset", {7'b0, tx_vld}, 8'h00);
   endtask

   task automatic t_read_basic();
      logic [7:0] b;
      read_once("R1", b);
      check("R1", "idle status byte", b, 8'h00);
      @(negedge clk);
      check("R6", "no offer after NoMAK", {7'b0, tx_vld}, 8'h00);
   endtask

   task automatic t_latch();
      logic [7:0] b;
      simple_cmd(8'h06);
      check("R2", "wel after set", {7'b0, wel}, 8'h01);
      read_once("R1", b);
      check("R1", "latch bit 1", b, 8'h02);
      simple_cmd(8'h04);
      check("R2", "wel after clear", {7'b0, wel}, 8'h00);
   endtask

   task automatic t_write_locked();
      write_status(8'h0C);
      @(negedge clk);
      check("R3", "bp unchanged without latch", {6'b0, bp}, 8'h00);
      check("R3", "no busy without latch", {7'b0, wip}, 8'h00);
   endtask

   task automatic t_write_timed();
      int hi;
      simple_cmd(8'h06);
      write_status(8'h0C);
      check("R3", "bp loaded", {6'b0, bp}, 8'h03);
      hi = 0;
      while (wip && hi < W + 10) begin
         hi++;
         @(negedge clk);
      end
      check("R4", "busy cycles", 8'(hi), 8'(W));
      check("R4", "wel cleared at end", {7'b0, wel}, 8'h00);
   endtask

   task automatic t_read_during_write();
      logic [7:0] b;
      int n;
      simple_cmd(8'h06);
      write_status(8'h04);
      put_byte(8'h05);
      put_ack(1'b1);
      take_byte("R8", b);
      check("R8", "new bp during write", b, 8'h07);
      n = 0;
      while (b !== 8'h04 && n < 100) begin
         put_ack(1'b1);
         take_byte("R7", b);
         n++;
      end
      put_ack(1'b0);
      check("R7", "repeat shows finished write", b, 8'h04);
      check("R6", "repeats occurred", {7'b0, (n > 1)}, 8'h01);
   endtask

   task automatic t_array_busy();
      logic [7:0] b;
      arr_busy = 1'b1;
      @(negedge clk);
      check("R5", "wip follows array busy", {7'b0, wip}, 8'h01);
      simple_cmd(8'h06);
      write_status(8'h00);
      check("R3", "bp kept while busy", {6'b0, bp}, 8'h01);
      check("R3", "wel kept when write refused", {7'b0, wel}, 8'h01);
      put_byte(8'h05);
      put_ack(1'b1);
      take_byte("R7", b);
      check("R7", "busy byte", b, 8'h07);
      arr_busy = 1'b0;
      put_ack(1'b1);
      take_byte("R7", b);
      check("R7", "byte after busy drops", b, 8'h06);
      put_ack(1'b0);
      arr_done = 1'b1;
      @(negedge clk);
      arr_done = 1'b0;
      check("R5", "array done clears wel", {7'b0, wel}, 8'h00);
   endtask

   task automatic t_unknown();
      put_byte(8'hAA);
      put_ack(1'b1);
      put_byte(8'h06);
      check("R10", "no offer for unknown", {7'b0, tx_vld}, 8'h00);
      put_ack(1'b0);
      @(negedge clk);
      check("R10", "wel untouched", {7'b0, wel}, 8'h00);
      check("R10", "bp untouched", {6'b0, bp}, 8'h01);
   endtask

   task automatic t_reset_keep();
      logic [7:0] b;
      simple_cmd(8'h06);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "wel cleared by reset", {7'b0, wel}, 8'h00);
      check("R9", "bp kept through reset", {6'b0, bp}, 8'h01);
      read_once("R9", b);
      check("R9", "status after reset", b, 8'h04);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nv_init_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_read_basic();
      t_latch();
      t_write_locked();
      t_write_timed();
      t_read_during_write();
      t_array_busy();
      t_unknown();
      t_reset_keep();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule